// File: doc/BRIEF.md
# Dual-Mode Programmable PLL Divider

This block is the digital counting section of a frequency synthesizer. It turns a crystal-side clock into a reference pulse train and a VCO-side clock into a synthesized pulse train. A phase comparator outside the block compares the two trains. Both source clocks reach the block as clock-enable strobes (`osc_en`, `vco_en`) in the system clock domain. Each divider advances only on its own strobe.

A 16-bit program word sets the synthesized ratio, and it can be read in two ways. In the pulse-swallow modes, its low 5 bits are a swallow count A and its upper 11 bits are a main count B. These counts drive a 32/33 dual-modulus prescaler, which the block models as counting logic. In direct mode, the whole word is one static count C. A 16-bit reference word sets the reference ratio. A 2-bit mode field selects swallow, direct or standby. Standby stops all division, forces both outputs low and presets the data words.

Software loads the words through a parallel write port. A new program or reference value takes effect only when the current period ends. A swallow setting with B below A is reported on an error output, and the synthesized output is blocked while that error stands.

Top module: `pll_dual_divider`

## Requirements
- R1: The mode field is written with `wr_sel`=2 and takes its value from `wr_data[1:0]`. 00 is standby, 01 is swallow (AM), 10 is direct, and 11 is swallow (FM). `wr_sel`=0 writes the program word and `wr_sel`=1 writes the reference word.
- R2: Outside standby, `ref_pulse` fires once every R+1 `osc_en` strobes, where R is the reference word.
- R3: In modes 01 and 11, `syn_pulse` fires once every 32·B + A + 32 `vco_en` strobes. A is program bits [4:0] and B is program bits [15:5].
- R4: In mode 10, `syn_pulse` fires once every C+1 `vco_en` strobes, where C is the full program word.
- R5: Each output pulse is high for exactly one clock cycle and directly follows a strobe edge, provided the ratio is greater than 1.
- R6: A program or reference write made during a period does not change that period. The new value governs the next period. The first period after leaving standby uses the values held at that moment.
- R7: In standby, counting stops and both `ref_pulse` and `syn_pulse` stay low.
- R8: Writing mode 00 presets both data words to 0xEFEF, which is the byte 0xEF in each byte. Reset leaves the block in standby with the same presets.
- R9: In modes 01 and 11 with B < A, `cfg_err` rises one cycle after the setting appears and `syn_pulse` stays low. When the setting becomes legal, `cfg_err` clears and pulses resume.
- R10: Division counts strobes, not clock cycles. With `vco_en` high on alternate cycles, the `syn_pulse` spacing in cycles doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 program, 1 reference, 2 mode |
| wr_data | input | 16 | Write data |
| osc_en | input | 1 | Crystal-side clock enable |
| vco_en | input | 1 | VCO-side clock enable |
| ref_pulse | output | 1 | Reference divider terminal-count pulse |
| syn_pulse | output | 1 | Synthesized divider terminal-count pulse |
| cfg_err | output | 1 | Illegal swallow setting (B < A) |

## Verification
The assertions check the following on every cycle:
- No pulse appears without a strobe in the previous cycle.
- A stopped divider stays quiet.
- The prescaler count never leaves its 33-state range.
- The direct and swallow paths never fire together.
- `cfg_err` blocks the synthesized output.
- A standby write presets the data words.

Only the bench scenarios can show that the pulse spacings equal R+1, 32B+A+32 and C+1, including under a half-rate strobe. The same applies to a mid-period write leaving the running period intact and to the 0xEFEF presets producing their long first period.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;

  typedef enum logic [1:0] {
    MODE_STBY   = 2'b00,
    MODE_AM_SW  = 2'b01,
    MODE_DIRECT = 2'b10,
    MODE_FM_SW  = 2'b11
  } div_mode_e;

  localparam logic [1:0] SEL_PROG = 2'd0;
  localparam logic [1:0] SEL_REF  = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  localparam logic [7:0] STBY_BYTE = 8'hEF;

endpackage

// File: rtl/div_regs.sv
module div_regs
  import synth_div_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] prog_q,
  output logic [W-1:0] ref_q,
  output div_mode_e    mode_q
);

  localparam logic [W-1:0] PRESET = {(W/8){STBY_BYTE}};

  logic go_stby;
  assign go_stby = wr_en && (wr_sel == SEL_MODE) && (wr_data[1:0] == MODE_STBY);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog_q <= PRESET;
      ref_q  <= PRESET;
      mode_q <= MODE_STBY;
    end else if (wr_en) begin
      case (wr_sel)
        SEL_PROG: prog_q <= wr_data;
        SEL_REF:  ref_q  <= wr_data;
        SEL_MODE: begin
          mode_q <= div_mode_e'(wr_data[1:0]);
          if (go_stby) begin
            prog_q <= PRESET;
            ref_q  <= PRESET;
          end
        end
        default: ;
      endcase
    end
  end

  // R8: a standby write leaves both data words at the preset pattern
  assert_standby_preset_R8: assert property (@(posedge clk) disable iff (rst)
    go_stby |=> (prog_q == PRESET) && (ref_q == PRESET));

endmodule

// File: rtl/down_divider.sv
module down_divider #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         tick,
  input  logic [W-1:0] load_val,
  output logic         pulse
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt   <= load_val;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt == '0) begin
          pulse <= 1'b1;
          cnt   <= load_val;
        end else begin
          cnt <= cnt - W'(1);
        end
      end
    end
  end

  // R5: a pulse only follows a strobe seen while running
  assert_pulse_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(tick) && $past(run)));

  // R7: a stopped divider is quiet on the next cycle
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !run |=> !pulse);

endmodule

// File: rtl/swallow_divider.sv
module swallow_divider #(
  parameter int A_W = 5,
  parameter int B_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run,
  input  logic           tick,
  input  logic [A_W-1:0] a_val,
  input  logic [B_W-1:0] b_val,
  output logic           pulse
);

  localparam int PRE = 1 << A_W;
  localparam logic [A_W:0] PSC_LONG  = (A_W+1)'(PRE);
  localparam logic [A_W:0] PSC_SHORT = (A_W+1)'(PRE - 1);

  logic [A_W:0]   psc;
  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic [A_W-1:0] a_nx;

  assign a_nx = (a_cnt != '0) ? a_cnt - A_W'(1) : '0;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      psc   <= (a_val != '0) ? PSC_LONG : PSC_SHORT;
      a_cnt <= a_val;
      b_cnt <= b_val;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (psc != '0) begin
          psc <= psc - (A_W+1)'(1);
        end else if (b_cnt == '0) begin
          pulse <= 1'b1;
          psc   <= (a_val != '0) ? PSC_LONG : PSC_SHORT;
          a_cnt <= a_val;
          b_cnt <= b_val;
        end else begin
          b_cnt <= b_cnt - B_W'(1);
          a_cnt <= a_nx;
          psc   <= (a_nx != '0) ? PSC_LONG : PSC_SHORT;
        end
      end
    end
  end

  // R3: the prescaler count stays within its 33-state range
  assert_psc_range_R3: assert property (@(posedge clk) disable iff (rst)
    psc <= PSC_LONG);

  // R5: a pulse only follows a strobe seen while running
  assert_pulse_after_tick_R5: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(tick) && $past(run)));

endmodule

// File: rtl/pll_dual_divider.sv
module pll_dual_divider
  import synth_div_pkg::*;
#(
  parameter int PROG_W    = 16,
  parameter int SWALLOW_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [PROG_W-1:0] wr_data,
  input  logic              osc_en,
  input  logic              vco_en,
  output logic              ref_pulse,
  output logic              syn_pulse,
  output logic              cfg_err
);

  localparam int MAIN_W = PROG_W - SWALLOW_W;

  logic [PROG_W-1:0]    prog_q;
  logic [PROG_W-1:0]    ref_q;
  div_mode_e            mode_q;
  logic [SWALLOW_W-1:0] a_val;
  logic [MAIN_W-1:0]    b_val;
  logic                 standby, swallow_sel, direct_sel, bad_cfg;
  logic                 dir_p, sw_p;

  div_regs #(.W(PROG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .prog_q(prog_q), .ref_q(ref_q), .mode_q(mode_q)
  );

  assign a_val       = prog_q[SWALLOW_W-1:0];
  assign b_val       = prog_q[PROG_W-1:SWALLOW_W];
  assign standby     = (mode_q == MODE_STBY);
  assign swallow_sel = (mode_q == MODE_AM_SW) || (mode_q == MODE_FM_SW);
  assign direct_sel  = (mode_q == MODE_DIRECT);
  assign bad_cfg     = swallow_sel &&
                       (b_val < {{(MAIN_W-SWALLOW_W){1'b0}}, a_val});

  down_divider #(.W(PROG_W)) u_ref_div (
    .clk(clk), .rst(rst), .run(!standby), .tick(osc_en),
    .load_val(ref_q), .pulse(ref_pulse)
  );

  down_divider #(.W(PROG_W)) u_dir_div (
    .clk(clk), .rst(rst), .run(direct_sel), .tick(vco_en),
    .load_val(prog_q), .pulse(dir_p)
  );

  swallow_divider #(.A_W(SWALLOW_W), .B_W(MAIN_W)) u_sw_div (
    .clk(clk), .rst(rst), .run(swallow_sel && !bad_cfg), .tick(vco_en),
    .a_val(a_val), .b_val(b_val), .pulse(sw_p)
  );

  assign syn_pulse = dir_p | sw_p;

  always_ff @(posedge clk) begin
    if (rst) cfg_err <= 1'b0;
    else     cfg_err <= bad_cfg;
  end

  // R9: an illegal swallow setting blocks the synthesized output
  assert_err_blocks_syn_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !syn_pulse);

  // R3, R4: only one synthesized path fires at a time
  assert_one_source_R4: assert property (@(posedge clk) disable iff (rst)
    !(dir_p && sw_p));

  // R7: both outputs stay low once standby has settled
  assert_standby_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    (standby && $past(standby)) |-> (!ref_pulse && !syn_pulse));

endmodule

// File: tb/tb_pll_dual_divider.sv
`timescale 1ns/1ps
module tb_pll_dual_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic        osc_en = 1'b1;
  logic        vco_en = 1'b1;
  logic        half = 1'b0;
  logic        ref_pulse, syn_pulse, cfg_err;

  int    n_chk = 0;
  int    n_fail = 0;
  longint cyc = 0;
  bit    done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) vco_en <= half ? ~vco_en : 1'b1;

  pll_dual_divider dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .osc_en(osc_en), .vco_en(vco_en),
    .ref_pulse(ref_pulse), .syn_pulse(syn_pulse), .cfg_err(cfg_err)
  );

  // {mode, program word, reference word}
  localparam logic [33:0] VECS [8] = '{
    {2'b01, 16'h00A3, 16'd9},
    {2'b11, 16'h051F, 16'd16},
    {2'b11, 16'h0000, 16'd1},
    {2'b10, 16'h0001, 16'd5},
    {2'b10, 16'h02BC, 16'd63},
    {2'b01, 16'h0063, 16'd2},
    {2'b11, 16'h03FF, 16'd100},
    {2'b10, 16'h1000, 16'd3}
  };

  function automatic longint exp_syn(logic [1:0] m, logic [15:0] p);
    if (m == 2'b10) return longint'(p) + 1;
    return 32 * longint'(p[15:5]) + longint'(p[4:0]) + 32;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [15:0] d, output longint t);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    t = cyc;
  endtask

  task automatic wait_pulse(bit syn, int maxc, output longint t);
    int n = 0;
    bit hit = 1'b0;
    t = 0;
    while (!hit && n <= maxc) begin
      @(negedge clk);
      n++;
      if (syn ? syn_pulse : ref_pulse) begin
        hit = 1'b1;
        t = cyc;
      end
    end
    if (!hit) check(1'b0, syn ? "timeout syn" : "timeout ref", n, maxc);
  endtask

  task automatic run_cfg(logic [1:0] m, logic [15:0] p, logic [15:0] r);
    longint t0, t1, t2, ta, tb, n;
    n = exp_syn(m, p);
    wr(2'd2, 16'd0, t0);
    wr(2'd0, p, t0);
    wr(2'd1, r, t0);
    wr(2'd2, {14'd0, m}, t0);
    wait_pulse(1'b1, 70000, t1);
    check(t1 - t0 == n, "R6 first period after standby", t1 - t0, n);
    @(negedge clk);
    check(!syn_pulse || n == 1, "R5 single-cycle syn pulse", syn_pulse, 0);
    wait_pulse(1'b1, 70000, t2);
    check(t2 - t1 == n, (m == 2'b10) ? "R4 direct period" : "R3 swallow period",
          t2 - t1, n);
    wait_pulse(1'b0, 70000, ta);
    wait_pulse(1'b0, 70000, tb);
    check(tb - ta == longint'(r) + 1, "R2 reference period", tb - ta, longint'(r) + 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    longint t0, t1, t2, t3, tr;
    int seen;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R8/R7: reset state is standby, nothing fires
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (ref_pulse || syn_pulse || cfg_err) seen++;
    end
    check(seen == 0, "R8 reset standby quiet", seen, 0);

    // R1-coded table walk
    foreach (VECS[i]) run_cfg(VECS[i][33:32], VECS[i][31:16], VECS[i][15:0]);

    // R3: random legal swallow settings
    void'($urandom(32'd11));
    for (int k = 0; k < 4; k++) begin
      int b, a, am;
      b  = int'($urandom % 64);
      am = (b < 31) ? b : 31;
      a  = int'($urandom % (am + 1));
      run_cfg((k % 2 == 0) ? 2'b01 : 2'b11, 16'((b << 5) | a),
              16'(int'($urandom % 50) + 1));
    end

    // R6: mid-period write does not shorten the running period
    run_cfg(2'b10, 16'd99, 16'd7);
    wait_pulse(1'b1, 70000, t1);
    repeat (10) @(negedge clk);
    wr(2'd0, 16'd49, t0);
    wait_pulse(1'b1, 70000, t2);
    check(t2 - t1 == 100, "R6 running period kept", t2 - t1, 100);
    wait_pulse(1'b1, 70000, t3);
    check(t3 - t2 == 50, "R6 new period applied", t3 - t2, 50);

    // R10: half-rate VCO strobe doubles spacing
    half = 1'b1;
    wr(2'd0, 16'd9, t0);
    wait_pulse(1'b1, 70000, t1);
    wait_pulse(1'b1, 70000, t1);
    wait_pulse(1'b1, 70000, t2);
    check(t2 - t1 == 20, "R10 strobe-counted period", t2 - t1, 20);
    half = 1'b0;

    // R9: illegal swallow B=2, A=5
    wr(2'd2, 16'd0, t0);
    wr(2'd0, 16'h0045, t0);
    wr(2'd2, 16'd1, t0);
    @(negedge clk);
    check(cfg_err == 1'b1, "R9 error flag raised", cfg_err, 1);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (syn_pulse) seen++;
    end
    check(seen == 0, "R9 syn held low", seen, 0);
    wr(2'd0, 16'h0041, t0);
    @(negedge clk);
    check(cfg_err == 1'b0, "R9 error flag cleared", cfg_err, 0);
    wait_pulse(1'b1, 70000, t1);
    wait_pulse(1'b1, 70000, t2);
    check(t2 - t1 == 97, "R9 recovered swallow period", t2 - t1, 97);

    // R7: standby silences outputs
    wr(2'd2, 16'd0, t0);
    @(negedge clk);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (ref_pulse || syn_pulse) seen++;
    end
    check(seen == 0, "R7 standby quiet", seen, 0);

    // R8: presets 0xEFEF give a first period of 61424 on both dividers
    wr(2'd2, 16'd2, t0);
    fork
      wait_pulse(1'b1, 70000, t1);
      wait_pulse(1'b0, 70000, tr);
    join
    check(t1 - t0 == 61424, "R8 program preset", t1 - t0, 61424);
    check(tr - t0 == 61424, "R8 reference preset", tr - t0, 61424);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule